// File: doc/BRIEF.md
# Power-Down Hold Controller

This block freezes a slice of programmable logic while the power-down feature is on and a request pin is high. Two request pins feed it, and either one can start power-down. When the feature is enabled, both pins are taken away from general logic use: the core sees zeros where those pins would have appeared. While the block is down, the registered copy of the input pins that the core consumes is frozen at its value on entry. The registered output values and their enables are frozen in the same way. No pin transition reaches the core until both requests have gone low again.

A separate, automatic standby mode watches the monitored inputs for transitions. After a configurable number of quiet clock cycles it raises a standby flag. The flag drops in the cycle that any input differs from the captured copy. Transition detection can be switched off, and then standby never asserts. Power-down takes precedence over standby.

The controller is a three-state machine:
- `PDH_RUN` is normal propagation.
- `PDH_STANDBY` is idle with no transitions.
- `PDH_DOWN` is frozen.

The transitions are:
- RUN to STANDBY when the quiet count completes.
- STANDBY to RUN when a transition is seen or detection is disabled.
- RUN or STANDBY to DOWN when a synchronised request is present.
- DOWN to RUN when both synchronised requests are low.

Top module: `pdhold_ctrl`

## Requirements
- R1: After reset, `low_power`, `standby`, `in_to_core`, `pin_val` and `pin_oe` are all zero.
- R2: With `pd_en`=1, a request pin (`pd_req_a` or `pd_req_b`) rising before a clock edge makes `low_power` assert after the third rising edge. It is still low after the second edge (two synchroniser stages plus the state register).
- R3: While `low_power` is high, `in_to_core` does not change, whatever `in_pins` does.
- R4: While `low_power` is high, `pin_val` and `pin_oe` keep their values, whatever `core_val` and `core_oe` do.
- R5: After both request pins fall, `low_power` clears after the third edge, and the held values are unchanged at that point. The next edge captures fresh inputs. There is no intermediate value.
- R6: With `pd_en`=1, `pd_to_core` reads 2'b00 regardless of the request pins.
- R7: With `pd_en`=0, the request pins never cause `low_power`. `pd_to_core` presents {`pd_req_b`,`pd_req_a`} (bit 1 = b, bit 0 = a) two edges after they change.
- R8: In normal operation, `in_to_core`, `pin_val` and `pin_oe` take the values of `in_pins`, `core_val` and `core_oe` one rising edge later.
- R9: With `itd_en`=1, `standby` asserts after IDLE_CYCLES+1 rising edges following a change on `in_pins`. The first edge captures the change, and IDLE_CYCLES quiet edges follow. It is low after IDLE_CYCLES edges.
- R10: While `standby` is high, `in_pins` differing from `in_to_core` clears `standby` in that same cycle, before the next edge.
- R11: With `itd_en`=0, `standby` stays low.
- R12: A synchronised power-down request clears `standby` at once, and `standby` and `low_power` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_en | input | 1 | Configuration: power-down feature enabled |
| itd_en | input | 1 | Configuration: transition-detect standby enabled |
| pd_req_a | input | 1 | Power-down request pin A (asynchronous) |
| pd_req_b | input | 1 | Power-down request pin B (asynchronous) |
| in_pins | input | N_IN | Incoming logic/pin signals |
| core_val | input | N_OUT | Output values produced by the core logic |
| core_oe | input | N_OUT | Output enables produced by the core logic |
| in_to_core | output | N_IN | Registered, holdable input copy for the core |
| pd_to_core | output | 2 | Request pins as logic inputs, zero when the feature is enabled |
| pin_val | output | N_OUT | Registered, holdable output values |
| pin_oe | output | N_OUT | Registered, holdable output enables |
| low_power | output | 1 | Power-down active |
| standby | output | 1 | Idle standby active |

## Verification
Standby and power-down can meet in one cycle. The bench lets `standby` assert through a quiet stretch of inputs, then raises a request pin. It judges that `standby` drops in the same cycle the synchronised request appears, and that `low_power` rises one edge later with the frozen values intact. An input transition and the exit from power-down can also coincide. The bench changes `in_pins` while the block is down and releases the pins. It then confirms that the exit edge leaves `in_to_core` unchanged and that only the following edge picks up the new value.

// File: rtl/pdh_pkg.sv
package pdh_pkg;
    typedef enum logic [1:0] {
        PDH_RUN     = 2'd0,
        PDH_STANDBY = 2'd1,
        PDH_DOWN    = 2'd2
    } pdh_state_e;

    localparam int unsigned PDH_REQ_PINS = 2;
endpackage

// File: rtl/pdh_sync.sv
module pdh_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pdh_idle.sv
module pdh_idle #(
    parameter int unsigned IDLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic change,
    output logic quiet_done
);
    localparam int unsigned CW = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

    logic [CW-1:0] quiet_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (clear || change) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != LAST) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assign quiet_done = (quiet_cnt == LAST);
endmodule

// File: rtl/pdh_fsm.sv
module pdh_fsm
    import pdh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_any,
    input  logic       itd_en,
    input  logic       quiet_done,
    input  logic       change,
    output pdh_state_e state,
    output logic       is_down,
    output logic       is_standby
);
    pdh_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PDH_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PDH_RUN: begin
                if (pd_any)
                    state_nx = PDH_DOWN;
                else if (itd_en && quiet_done && !change)
                    state_nx = PDH_STANDBY;
            end
            PDH_STANDBY: begin
                if (pd_any)
                    state_nx = PDH_DOWN;
                else if (change || !itd_en)
                    state_nx = PDH_RUN;
            end
            PDH_DOWN: begin
                if (!pd_any)
                    state_nx = PDH_RUN;
            end
            default: state_nx = PDH_RUN;
        endcase
    end

    always_comb begin
        is_down    = (state == PDH_DOWN);
        is_standby = (state == PDH_STANDBY);
    end
endmodule

// File: rtl/pdh_hold.sv
module pdh_hold #(
    parameter int unsigned N_IN  = 8,
    parameter int unsigned N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [N_IN-1:0]  in_pins,
    input  logic [N_OUT-1:0] core_val,
    input  logic [N_OUT-1:0] core_oe,
    output logic [N_IN-1:0]  in_q,
    output logic [N_OUT-1:0] val_q,
    output logic [N_OUT-1:0] oe_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '0;
        end else if (!hold) begin
            in_q <= in_pins;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            oe_q  <= '0;
        end else if (!hold) begin
            val_q <= core_val;
            oe_q  <= core_oe;
        end
    end
endmodule

// File: rtl/pdhold_ctrl.sv
module pdhold_ctrl
    import pdh_pkg::*;
#(
    parameter int unsigned N_IN        = 8,
    parameter int unsigned N_OUT       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned IDLE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_en,
    input  logic             itd_en,
    input  logic             pd_req_a,
    input  logic             pd_req_b,
    input  logic [N_IN-1:0]  in_pins,
    input  logic [N_OUT-1:0] core_val,
    input  logic [N_OUT-1:0] core_oe,
    output logic [N_IN-1:0]  in_to_core,
    output logic [1:0]       pd_to_core,
    output logic [N_OUT-1:0] pin_val,
    output logic [N_OUT-1:0] pin_oe,
    output logic             low_power,
    output logic             standby
);
    logic [PDH_REQ_PINS-1:0] req_raw;
    logic [PDH_REQ_PINS-1:0] req_sync;
    logic                    pd_any;
    logic                    hold;
    logic                    change;
    logic                    quiet_done;
    logic                    is_down;
    logic                    is_standby;
    pdh_state_e              state;

    assign req_raw = {pd_req_b, pd_req_a};

    generate
        for (genvar p = 0; p < PDH_REQ_PINS; p++) begin : g_req
            pdh_sync #(.STAGES(SYNC_STAGES)) sync_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .d_async (req_raw[p]),
                .q_sync  (req_sync[p])
            );
        end
    endgenerate

    assign pd_any     = pd_en & (|req_sync);
    assign pd_to_core = pd_en ? 2'b00 : req_sync;
    assign hold       = is_down | pd_any;
    assign change     = (in_pins != in_to_core);

    pdh_hold #(.N_IN(N_IN), .N_OUT(N_OUT)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .in_pins  (in_pins),
        .core_val (core_val),
        .core_oe  (core_oe),
        .in_q     (in_to_core),
        .val_q    (pin_val),
        .oe_q     (pin_oe)
    );

    pdh_idle #(.IDLE_CYCLES(IDLE_CYCLES)) idle_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (hold | ~itd_en),
        .change     (change),
        .quiet_done (quiet_done)
    );

    pdh_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_any     (pd_any),
        .itd_en     (itd_en),
        .quiet_done (quiet_done),
        .change     (change),
        .state      (state),
        .is_down    (is_down),
        .is_standby (is_standby)
    );

    always_comb begin
        low_power = is_down;
        standby   = is_standby & itd_en & ~change & ~hold;
    end
endmodule

// File: rtl/pdh_chk.sv
module pdh_chk #(
    parameter int unsigned N_IN  = 8,
    parameter int unsigned N_OUT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pd_en,
    input logic             itd_en,
    input logic [N_IN-1:0]  in_to_core,
    input logic [N_OUT-1:0] pin_val,
    input logic [N_OUT-1:0] pin_oe,
    input logic             low_power,
    input logic             standby
);
    p_hold_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |=> $stable(in_to_core));

    p_hold_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |=> ($stable(pin_val) && $stable(pin_oe)));

    p_clean_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(low_power) |-> $stable(in_to_core));

    p_no_pd_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_en |=> !low_power);

    p_itd_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !itd_en |-> !standby);

    p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(low_power && standby));
endmodule

bind pdhold_ctrl pdh_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_en      (pd_en),
    .itd_en     (itd_en),
    .in_to_core (in_to_core),
    .pin_val    (pin_val),
    .pin_oe     (pin_oe),
    .low_power  (low_power),
    .standby    (standby)
);

// File: tb/pdhold_ctrl_tb.sv
module pdhold_ctrl_tb_top;
    localparam int unsigned NI = 8;
    localparam int unsigned NO = 8;
    localparam int unsigned IC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pd_en = 1'b0;
    logic          itd_en = 1'b0;
    logic          pd_req_a = 1'b0;
    logic          pd_req_b = 1'b0;
    logic [NI-1:0] in_pins = '0;
    logic [NO-1:0] core_val = '0;
    logic [NO-1:0] core_oe = '0;
    logic [NI-1:0] in_to_core;
    logic [1:0]    pd_to_core;
    logic [NO-1:0] pin_val;
    logic [NO-1:0] pin_oe;
    logic          low_power;
    logic          standby;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pdhold_ctrl #(.N_IN(NI), .N_OUT(NO), .SYNC_STAGES(2), .IDLE_CYCLES(IC)) dut_i (
        .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .itd_en(itd_en),
        .pd_req_a(pd_req_a), .pd_req_b(pd_req_b), .in_pins(in_pins),
        .core_val(core_val), .core_oe(core_oe), .in_to_core(in_to_core),
        .pd_to_core(pd_to_core), .pin_val(pin_val), .pin_oe(pin_oe),
        .low_power(low_power), .standby(standby)
    );

    // Each entry: {in_pins, core_val, core_oe}
    localparam logic [23:0] VEC [8] = '{
        24'hA5_3C_FF, 24'h5A_C3_00, 24'hFF_01_80, 24'h00_FE_7F,
        24'h81_18_55, 24'h7E_E7_AA, 24'h12_34_56, 24'hED_CB_A9
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [23:0] v);
        in_pins  = v[23:16];
        core_val = v[15:8];
        core_oe  = v[7:0];
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1 reset state
        chk("R1 low_power", 32'(low_power), 0);
        chk("R1 standby", 32'(standby), 0);
        chk("R1 in_to_core", 32'(in_to_core), 0);
        chk("R1 pin_val", 32'(pin_val), 0);
        chk("R1 pin_oe", 32'(pin_oe), 0);
        rst_n = 1'b1;
        step(1);

        // R8 table walk of normal propagation
        for (int i = 0; i < 8; i++) begin
            drive(VEC[i]);
            step(1);
            chk("R8 in_to_core", 32'(in_to_core), 32'(VEC[i][23:16]));
            chk("R8 pin_val", 32'(pin_val), 32'(VEC[i][15:8]));
            chk("R8 pin_oe", 32'(pin_oe), 32'(VEC[i][7:0]));
        end

        // R2 entry via pin A, R6 masking
        pd_en = 1'b1;
        drive(24'h11_22_33);
        step(1);
        pd_req_a = 1'b1;
        step(2);
        chk("R2 not yet", 32'(low_power), 0);
        chk("R6 pd_to_core", 32'(pd_to_core), 0);
        step(1);
        chk("R2 low_power", 32'(low_power), 1);

        // R3, R4 hold while down
        drive(24'hEE_DD_CC);
        step(3);
        chk("R3 in_to_core held", 32'(in_to_core), 32'h11);
        chk("R4 pin_val held", 32'(pin_val), 32'h22);
        chk("R4 pin_oe held", 32'(pin_oe), 32'h33);
        chk("R6 pd_to_core while down", 32'(pd_to_core), 0);

        // R5 exit timing
        pd_req_a = 1'b0;
        step(2);
        chk("R5 still down", 32'(low_power), 1);
        step(1);
        chk("R5 low_power cleared", 32'(low_power), 0);
        chk("R5 exit edge holds", 32'(in_to_core), 32'h11);
        chk("R5 exit edge holds val", 32'(pin_val), 32'h22);
        step(1);
        chk("R5 resume in", 32'(in_to_core), 32'hEE);
        chk("R5 resume val", 32'(pin_val), 32'hDD);

        // R2 entry via pin B
        pd_req_b = 1'b1;
        step(3);
        chk("R2 pin b", 32'(low_power), 1);
        pd_req_b = 1'b0;
        step(4);
        chk("R5 pin b exit", 32'(low_power), 0);

        // R7 feature disabled
        pd_en = 1'b0;
        pd_req_a = 1'b1;
        step(2);
        chk("R7 pd_to_core", 32'(pd_to_core), 32'h1);
        step(3);
        chk("R7 no power-down", 32'(low_power), 0);
        pd_req_a = 1'b0;
        pd_req_b = 1'b1;
        step(2);
        chk("R7 pd_to_core b", 32'(pd_to_core), 32'h2);
        pd_req_b = 1'b0;
        step(3);

        // R9 standby after quiet period
        pd_en = 1'b1;
        itd_en = 1'b1;
        in_pins = 8'h3C;
        step(1);
        step(IC - 1);
        chk("R9 standby not yet", 32'(standby), 0);
        step(1);
        chk("R9 standby", 32'(standby), 1);

        // R10 clear on change, same cycle
        in_pins = 8'hC3;
        #1;
        chk("R10 standby cleared", 32'(standby), 0);
        step(1);
        chk("R10 standby after edge", 32'(standby), 0);

        // R12 power-down request during standby
        step(IC + 1);
        chk("R12 standby reached", 32'(standby), 1);
        pd_req_a = 1'b1;
        step(2);
        chk("R12 standby dropped", 32'(standby), 0);
        step(1);
        chk("R12 low_power", 32'(low_power), 1);
        chk("R12 held", 32'(in_to_core), 32'hC3);
        pd_req_a = 1'b0;
        step(4);

        // R11 detection disabled
        itd_en = 1'b0;
        step(IC + 6);
        chk("R11 no standby", 32'(standby), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule